// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects a parameterised set of level-sensitive peripheral interrupt lines (32, 64 or 128 of them) and drives one interrupt request line per CPU. Each CPU owns a private bank of memory-mapped registers. A source reaches a CPU only when that CPU's bank has the matching enable bit set, so any source can be steered to one CPU, to several or to none.

The block does no prioritisation and no queuing. It has no edge detection and no polarity control. A CPU's request line is high while at least one enabled source is high. Software finds out which sources are pending by reading every status word of its own bank.

Inputs are resynchronised in two flops before masking. Both the request lines and the read data are registered. Registers are reached over a simple 32-bit bus with one-cycle strobes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable bit is 0, every irqOut line is 0, and every enable word reads as zero.
- R2: Bank c starts at byte address c*8*NW, where NW = NUM_SRC/32. Within a bank, enable word w is at byte offset 4*w and status word w is at byte offset 4*(NW+w). Word w covers sources 32*w to 32*w+31, with bit b of the word mapping to source 32*w+b. With 128 sources a bank spans 0x20 bytes. Address bits [1:0] are ignored.
- R3: An enable word is written only as a whole 32-bit word, and a read returns exactly the last value written.
- R4: A status word reads as the synchronised source levels ANDed with the same bank's enable word.
- R5: A write to a status offset changes no register.
- R6: irqOut[c] is 1 exactly when some source is high and enabled in bank c. It reflects a change on irqIn after the third rising clock edge, and an enable write after the second rising edge counted from the write edge.
- R7: Banks are independent: writing one bank's enables leaves the other banks' enables and request lines unchanged.
- R8: An address whose bank index is NUM_CPU or more reads as zero, and a write to it has no effect.
- R9: busRdData and busRdValid update on the rising edge that samples busRdEn. busRdValid is high for exactly the cycle after each read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC | Level interrupt sources |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle |
| busRdEn | input | 1 | Read strobe, one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| irqOut | output | NUM_CPU | Per-CPU interrupt request |

## Verification
Read data is due on the cycle after the read strobe. The read task pushes its expected word into a queue, and a monitor pops and compares that word on the falling edge when busRdValid is high. A change on irqIn is due on irqOut after the third rising edge. The bench therefore checks the old value after two edges and the new value after three, so a missing or extra stage is caught. An enable write is due on irqOut one edge after the write edge, and it is checked both at the falling edge that ends the write and at the next falling edge. Status reads are issued only after the three-edge synchroniser delay has elapsed.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic hit;
    logic isStatus;
  } busStrobe_t;

  function automatic int selW(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_CPU   = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWrEn,
  input  logic                           busRdEn,
  output busStrobe_t                     strobe,
  output logic [selW(NUM_CPU)-1:0]       cpuSel,
  output logic [selW(NUM_WORDS)-1:0]     wordSel
);

  localparam int CPU_W = selW(NUM_CPU);
  localparam int OFF_W = $clog2(2 * NUM_WORDS);
  localparam int IDX_W = ADDR_W - 2 - OFF_W;

  logic [ADDR_W-3:0] wordAddr;
  logic [OFF_W-1:0]  offset;
  logic [IDX_W-1:0]  bankIdx;
  logic              unusedByteLane;

  // byte lanes are not decoded: whole-word access only
  assign unusedByteLane = ^busAddr[1:0];
  assign wordAddr = busAddr[ADDR_W-1:2];
  assign offset   = wordAddr[OFF_W-1:0];
  assign bankIdx  = wordAddr[ADDR_W-3:OFF_W];

  assign strobe.wrEn     = busWrEn;
  assign strobe.rdEn     = busRdEn;
  assign strobe.hit      = (bankIdx < IDX_W'(NUM_CPU));
  assign strobe.isStatus = offset[OFF_W-1];
  assign cpuSel          = CPU_W'(bankIdx);

  generate
    if (NUM_WORDS > 1) begin : gWordIdx
      assign wordSel = offset[OFF_W-2:0];
    end else begin : gSingleWord
      assign wordSel = '0;
    end
  endgenerate

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_SRC-1:0]                   irqIn,
  input  busStrobe_t                           strobe,
  input  logic [selW(NUM_CPU)-1:0]             cpuSel,
  input  logic [selW(NUM_SRC/32)-1:0]          wordSel,
  input  logic [31:0]                          wrData,
  output logic [31:0]                          rdData,
  output logic                                 rdValid,
  output logic [NUM_CPU-1:0]                   irqOut
);

  localparam int NUM_WORDS = NUM_SRC / 32;

  logic [NUM_SRC-1:0]                       syncA;
  logic [NUM_SRC-1:0]                       syncB;
  logic [NUM_WORDS-1:0][31:0]               srcWords;
  logic [NUM_CPU-1:0][NUM_WORDS-1:0][31:0]  enReg;
  logic [NUM_CPU-1:0][NUM_WORDS-1:0][31:0]  maskedWord;
  logic [NUM_CPU-1:0]                       anyPend;
  logic [31:0]                              selEnWord;
  logic [31:0]                              rdNext;
  logic                                     enWrite;

  // two-flop synchroniser on every source line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
    end
  end

  assign srcWords = syncB;
  assign enWrite  = strobe.wrEn && strobe.hit && !strobe.isStatus;

  // enable banks, whole-word writes only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (enWrite) begin
      enReg[cpuSel][wordSel] <= wrData;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
      for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
        assign maskedWord[c][w] = srcWords[w] & enReg[c][w];
      end
      assign anyPend[c] = |maskedWord[c];

      always_ff @(posedge clk) begin
        if (!rstN) irqOut[c] <= 1'b0;
        else       irqOut[c] <= anyPend[c];
      end

      AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
        ($past(enReg[c]) == '0) |-> !irqOut[c]); // R6
    end
  endgenerate

  assign selEnWord = enReg[cpuSel][wordSel];

  always_comb begin
    if (!strobe.hit)          rdNext = '0;
    else if (strobe.isStatus) rdNext = maskedWord[cpuSel][wordSel];
    else                      rdNext = selEnWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdNext;
    end
  end

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.isStatus) |=> $stable(enReg)); // R5

  AST_MISS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.hit) |=> $stable(enReg)); // R8

  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !strobe.hit) |=> (rdData == '0)); // R8

  AST_STATUS_WITHIN_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.hit && strobe.isStatus) |=> ((rdData & ~$past(selEnWord)) == '0)); // R4

  AST_RDVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rdValid); // R9

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> !rdValid); // R9

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               busRdValid,
  output logic [NUM_CPU-1:0] irqOut
);

  localparam int NUM_WORDS = NUM_SRC / 32;

  busStrobe_t                   strobe;
  logic [selW(NUM_CPU)-1:0]     cpuSel;
  logic [selW(NUM_WORDS)-1:0]   wordSel;

  irq_agg_ctrl #(
    .NUM_CPU  (NUM_CPU),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe),
    .cpuSel (cpuSel),
    .wordSel(wordSel)
  );

  irq_agg_datapath #(
    .NUM_SRC(NUM_SRC),
    .NUM_CPU(NUM_CPU)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strobe (strobe),
    .cpuSel (cpuSel),
    .wordSel(wordSel),
    .wrData (busWrData),
    .rdData (busRdData),
    .rdValid(busRdValid),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 2;
  localparam int ADDR_W  = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] irqIn = '0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic               busWrEn = 1'b0;
  logic               busRdEn = 1'b0;
  logic [31:0]        busWrData = '0;
  logic [31:0]        busRdData;
  logic               busRdValid;
  logic [NUM_CPU-1:0] irqOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  irq_aggregator #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: compares each read result as the design presents it
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        chk("R9 unexpected read valid", 32'd1, 32'd0);
      end else begin
        chk(tagQ.pop_front(), busRdData, expQ.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);

    // reset state
    chk("R1 irqOut after reset", 32'(irqOut), 32'd0);
    chk("R9 rdValid idle", 32'(busRdValid), 32'd0);
    busRead(8'h00, 32'h0, "R1 bank0 en0 reset");
    busRead(8'h04, 32'h0, "R1 bank0 en1 reset");
    busRead(8'h10, 32'h0, "R1 bank1 en0 reset");
    busRead(8'h14, 32'h0, "R1 bank1 en1 reset");

    // whole-word enables and bank independence
    busWrite(8'h00, 32'h0000_00F0);
    busWrite(8'h14, 32'h8000_0001);
    busRead(8'h00, 32'h0000_00F0, "R3 bank0 en0 readback");
    busRead(8'h14, 32'h8000_0001, "R3 bank1 en1 readback");
    busRead(8'h04, 32'h0, "R7 bank0 en1 untouched");
    busRead(8'h10, 32'h0, "R7 bank1 en0 untouched");
    busWrite(8'h07, 32'hA5A5_5A5A);
    busRead(8'h04, 32'hA5A5_5A5A, "R2 byte lanes ignored R3 full word");
    busWrite(8'h04, 32'h0);

    // source 4 rises: visible on irqOut[0] after the third edge
    @(negedge clk);
    irqIn[4] = 1'b1;
    waitNeg(2);
    chk("R6 irqOut0 still low after two edges", 32'(irqOut[0]), 32'd0);
    waitNeg(1);
    chk("R6 irqOut0 high after three edges", 32'(irqOut[0]), 32'd1);
    chk("R7 irqOut1 not enabled for source 4", 32'(irqOut[1]), 32'd0);
    busRead(8'h08, 32'h0000_0010, "R4 bank0 status0");
    busRead(8'h18, 32'h0, "R4 bank1 status0 masked");

    // sources 32 and 63 (word 1 bits 0 and 31) reach bank 1
    @(negedge clk);
    irqIn[32] = 1'b1;
    irqIn[63] = 1'b1;
    irqIn[40] = 1'b1;
    waitNeg(3);
    chk("R6 irqOut1 high", 32'(irqOut[1]), 32'd1);
    busRead(8'h1C, 32'h8000_0001, "R2 bank1 status1 R4 masked");
    busRead(8'h0C, 32'h0, "R4 bank0 status1 disabled");

    // writes to status are ignored
    busWrite(8'h08, 32'hFFFF_FFFF);
    busWrite(8'h1C, 32'h0);
    busRead(8'h00, 32'h0000_00F0, "R5 bank0 en0 after status write");
    busRead(8'h14, 32'h8000_0001, "R5 bank1 en1 after status write");
    busRead(8'h08, 32'h0000_0010, "R5 bank0 status0 unchanged");

    // out-of-range addresses
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'h40, 32'hFFFF_FFFF);
    busWrite(8'hF4, 32'hFFFF_FFFF);
    busRead(8'h20, 32'h0, "R8 miss read 0x20");
    busRead(8'h48, 32'h0, "R8 miss read 0x48");
    busRead(8'h04, 32'h0, "R8 bank0 en1 unchanged");
    busRead(8'h10, 32'h0, "R8 bank1 en0 unchanged");
    chk("R8 irqOut unchanged", 32'(irqOut), 32'd3);

    // source 4 falls: irqOut[0] drops after the third edge
    @(negedge clk);
    irqIn[4] = 1'b0;
    waitNeg(2);
    chk("R6 irqOut0 holds after two edges", 32'(irqOut[0]), 32'd1);
    waitNeg(1);
    chk("R6 irqOut0 low after three edges", 32'(irqOut[0]), 32'd0);

    // enable-write latency: irqOut[0] rises one edge after the write edge
    @(negedge clk);
    irqIn[5] = 1'b1;
    waitNeg(3);
    chk("R6 irqOut0 high for source 5", 32'(irqOut[0]), 32'd1);
    busWrite(8'h00, 32'h0);
    chk("R6 irqOut0 high at end of write", 32'(irqOut[0]), 32'd1);
    waitNeg(1);
    chk("R6 irqOut0 low one edge after write", 32'(irqOut[0]), 32'd0);
    chk("R7 irqOut1 unaffected by bank0 write", 32'(irqOut[1]), 32'd1);
    busWrite(8'h04, 32'h0000_0100);
    waitNeg(1);
    chk("R6 irqOut0 high from word1 enable", 32'(irqOut[0]), 32'd1);
    busRead(8'h0C, 32'h0000_0100, "R4 bank0 status1 source 40");

    waitNeg(2);
    chk("R9 every read returned", 32'(expQ.size()), 32'd0);
    chk("R9 rdValid idle at end", 32'(busRdValid), 32'd0);
    finish_run();
  end

endmodule